// File: doc/BRIEF.md
# I2C Master Start Condition Generator with Collision Detection

This block issues the Start condition of an I2C master and watches the bus for collisions while it does so. A one-cycle request starts the sequence. The block then runs two timed phases. Each phase lasts a number of clock cycles set by a 7-bit reload value. In the first phase SDA is released. In the second phase SDA is pulled low. At the end of the second phase SCL is also pulled low, which completes the Start. The block then keeps both lines low so that the logic for the address phase can take over. The bus is released again only by reset.

The block reads SDA and SCL through samples that are already synchronized. It drives each pad through a drive-low enable, because the pads are open-drain. A collision is declared only in these cases:
- either line is low when the request is accepted;
- SCL goes low while SDA is still high during the first phase.

SDA going low early during the first phase is not a collision. It ends the first phase at once. SCL going low during the second phase is ignored. On a collision the block releases both lines and returns to idle. The collision flag and the interrupt flag stay set until they are cleared.

Top module: `i2c_start_gen`

## Requirements
- R1: A request taken while idle with both sda_i and scl_i high starts the sequence. If either line is low at that edge, the sequence is aborted: coll_o and irq_o are high after that edge, busy_o stays low, and both drive enables stay low.
- R2: Each phase lasts N cycles, where N = max(reload_i, 1). Count k from 0 at the accepting edge. When the first phase runs undisturbed, sda_drv_o goes high after edge N.
- R3: In the first phase, scl_i low while sda_i is high at edge k declares a collision. After that edge, busy_o and both drive enables are low, and coll_o and irq_o are high.
- R4: In the first phase, sda_i low at edge k ends the phase early with no collision. sda_drv_o is high after edge k, and the second phase of N cycles starts from that edge.
- R5: scl_drv_o goes high N edges after sda_drv_o goes high. A low scl_i during the second phase has no effect on the timing or on the flags.
- R6: At completion, done_o is high for exactly one cycle and irq_o goes high. Both drive enables then stay high until reset, and requests are ignored from then on.
- R7: busy_o is high after the accepting edge and stays high until the sequence completes or aborts. A request that arrives while busy_o is high is ignored.
- R8: coll_o and irq_o stay set until flag_clr_i is high at an edge, and they are low after that edge. If a new event sets a flag at the same edge as a clear, the set wins.
- R9: A reload value of 0 behaves exactly like a reload value of 1.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| reload_i | input | 7 | Cycle count for each phase |
| sda_i | input | 1 | Synchronized sample of SDA |
| scl_i | input | 1 | Synchronized sample of SCL |
| flag_clr_i | input | 1 | Clears the collision and interrupt flags |
| sda_drv_o | output | 1 | Drive-low enable for the SDA pad |
| scl_drv_o | output | 1 | Drive-low enable for the SCL pad |
| busy_o | output | 1 | Start sequence in progress |
| done_o | output | 1 | One-cycle strobe when the Start completes |
| irq_o | output | 1 | Sticky interrupt flag |
| coll_o | output | 1 | Sticky bus collision flag |

## Verification
The two internal states that can go wrong are the phase state and the phase counter. A wrong phase state shows on the drive enables or on busy_o in the cycle right after the faulty edge. A wrong counter shows as sda_drv_o or scl_drv_o changing one or more cycles away from the edges N and 2N counted from acceptance. The bench therefore compares every output against arithmetic expectations after every edge. A collision that is missed, or one that is wrongly declared, changes coll_o and busy_o in the cycle after the disturbing sample.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_OWN   = 2'd3
  } start_st_e;
endpackage

// File: rtl/i2c_start_brg.sv
module i2c_start_brg #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // zero reload still gives a one-cycle phase
  assign load_val = (reload_i == '0) ? ONE : reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (dec_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last_o = (cnt_q <= ONE);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      sda_i,
  input  logic      scl_i,
  input  logic      last_i,
  output start_st_e st_o,
  output logic      load_o,
  output logic      dec_o,
  output logic      coll_evt_o,
  output logic      done_evt_o
);
  start_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    dec_o      = 1'b0;
    coll_evt_o = 1'b0;
    done_evt_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (sda_i && scl_i) begin
            st_d   = ST_SETUP;
            load_o = 1'b1;
          end else begin
            coll_evt_o = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (!sda_i) begin
          // another master pulled SDA first: assert early, no collision
          st_d   = ST_HOLD;
          load_o = 1'b1;
        end else if (!scl_i) begin
          st_d       = ST_IDLE;
          coll_evt_o = 1'b1;
        end else if (last_i) begin
          st_d   = ST_HOLD;
          load_o = 1'b1;
        end else begin
          dec_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (last_i) begin
          st_d       = ST_OWN;
          done_evt_o = 1'b1;
        end else begin
          dec_o = 1'b1;
        end
      end
      ST_OWN: st_d = ST_OWN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/i2c_start_flags.sv
module i2c_start_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coll_evt_i,
  input  logic done_evt_i,
  input  logic clr_i,
  output logic done_o,
  output logic irq_o,
  output logic coll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
      coll_o <= 1'b0;
    end else begin
      done_o <= done_evt_i;
      // set has priority over clear
      if (coll_evt_i || done_evt_i) irq_o <= 1'b1;
      else if (clr_i)               irq_o <= 1'b0;
      if (coll_evt_i)               coll_o <= 1'b1;
      else if (clr_i)               coll_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             flag_clr_i,
  output logic             sda_drv_o,
  output logic             scl_drv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             coll_o
);
  start_st_e st;
  logic      load, dec, last, coll_evt, done_evt;

  i2c_start_brg #(.CNT_W(CNT_W)) i_brg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .dec_i    (dec),
    .reload_i (reload_i),
    .last_o   (last)
  );

  i2c_start_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .last_i     (last),
    .st_o       (st),
    .load_o     (load),
    .dec_o      (dec),
    .coll_evt_o (coll_evt),
    .done_evt_o (done_evt)
  );

  i2c_start_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .coll_evt_i (coll_evt),
    .done_evt_i (done_evt),
    .clr_i      (flag_clr_i),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .coll_o     (coll_o)
  );

  assign sda_drv_o = (st == ST_HOLD) || (st == ST_OWN);
  assign scl_drv_o = (st == ST_OWN);
  assign busy_o    = (st == ST_SETUP) || (st == ST_HOLD);
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flag_clr_i,
  input logic sda_drv_o,
  input logic scl_drv_o,
  input logic busy_o,
  input logic done_o,
  input logic irq_o,
  input logic coll_o
);
  // R6
  done_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sda_drv_o && scl_drv_o && irq_o));

  // R5
  scl_after_sda_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drv_o) |-> $past(sda_drv_o));

  // R6
  own_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drv_o |=> (scl_drv_o && sda_drv_o && !busy_o));

  // R3
  coll_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) |-> (!sda_drv_o && !scl_drv_o && !busy_o));

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || coll_o));

  // R8
  coll_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && !flag_clr_i) |=> coll_o);

  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr_i) |=> irq_o);
endmodule

bind i2c_start_gen i2c_start_gen_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flag_clr_i (flag_clr_i),
  .sda_drv_o  (sda_drv_o),
  .scl_drv_o  (scl_drv_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .irq_o      (irq_o),
  .coll_o     (coll_o)
);

// File: tb/test_i2c_start_gen.sv
module test_i2c_start_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] reload_i = '0;
  logic       sda_i = 1'b1;
  logic       scl_i = 1'b1;
  logic       flag_clr_i = 1'b0;
  logic       sda_drv_o, scl_drv_o, busy_o, done_o, irq_o, coll_o;

  int vecs = 0;
  int errs = 0;

  always #2 clk_i = ~clk_i;

  i2c_start_gen i_i2c_start_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .reload_i   (reload_i),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .flag_clr_i (flag_clr_i),
    .sda_drv_o  (sda_drv_o),
    .scl_drv_o  (scl_drv_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .coll_o     (coll_o)
  );

  // packed as {busy, sda_drv, scl_drv, done, coll, irq}
  task automatic check(input string tag, input logic [5:0] exp, input int rl, input int k);
    logic [5:0] act;
    act = {busy_o, sda_drv_o, scl_drv_o, done_o, coll_o, irq_o};
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s reload=%0d k=%0d act=%b exp=%b", tag, rl, k, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; start_i = 0; sda_i = 1; scl_i = 1; flag_clr_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // modes: 0 normal, 1 abort sda, 2 abort scl, 3 scl collision at j,
  // 4 early sda at j, 5 scl low in second phase, 6 extra start at j,
  // 7 abort then clear at j, 8 abort with clear at same edge
  task automatic run(input int rl, input int mode, input int j);
    int    n, kmax, t;
    string tag;
    logic  b, sd, sc, dn, co, iq;
    do_reset();
    reload_i = 7'(rl);
    n = (rl == 0) ? 1 : rl;
    kmax = 2 * n + 3;
    if (mode == 4) kmax = j + n + 3;
    if (mode inside {1, 2, 7, 8}) kmax = 5;
    if (mode == 6 && j > kmax) kmax = j + 2;
    case (mode)
      0: tag = (rl == 0) ? "R9" : "R2";
      1, 2: tag = "R1";
      3: tag = "R3";
      4: tag = "R4";
      5: tag = "R5";
      6: tag = (j > 2 * n) ? "R6" : "R7";
      default: tag = "R8";
    endcase
    for (int k = 0; k <= kmax; k++) begin
      start_i    = (k == 0) || (mode == 6 && k == j);
      sda_i      = !((mode == 1 && k == 0) || (mode == 4 && k >= j));
      scl_i      = !((mode == 2 && k == 0) || (mode inside {7, 8} && k == 0) ||
                     (mode == 3 && k >= j) || (mode == 5 && k > n));
      flag_clr_i = (mode == 7 && k == j) || (mode == 8 && k == 0);
      @(negedge clk_i);
      start_i = 1'b0;
      if (mode inside {1, 2, 8}) begin
        b = 0; sd = 0; sc = 0; dn = 0; co = 1; iq = 1;
      end else if (mode == 7) begin
        b = 0; sd = 0; sc = 0; dn = 0; co = (k < j); iq = (k < j);
      end else if (mode == 3) begin
        b = (k < j); sd = 0; sc = 0; dn = 0; co = (k >= j); iq = (k >= j);
      end else begin
        t = (mode == 4) ? j : n;
        b = (k < t + n); sd = (k >= t); sc = (k >= t + n);
        dn = (k == t + n); co = 0; iq = (k >= t + n);
      end
      check(tag, {b, sd, sc, dn, co, iq}, rl, k);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R10 reset state
    @(negedge clk_i);
    check("R10", 6'b0, 0, -1);
    rst_ni = 1'b1;
    for (int rl = 0; rl < 128; rl++) run(rl, 0, 0);
    run(5, 1, 0);
    run(5, 2, 0);
    run(0, 1, 0);
    for (int rl = 0; rl <= 16; rl++) begin
      for (int j = 1; j <= ((rl == 0) ? 1 : rl); j++) begin
        run(rl, 3, j);
        run(rl, 4, j);
      end
    end
    for (int rl = 0; rl <= 12; rl++) run(rl, 5, 0);
    for (int j = 1; j <= 9; j++) run(4, 6, j);
    run(3, 6, 7);
    run(6, 7, 2);
    run(6, 7, 4);
    run(6, 8, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule